// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands over a fixed number of clock cycles. A shift-and-add datapath does the arithmetic, and a small state machine controls it. A one-cycle start pulse loads both operands. The block then runs with no further control until the full double-width product is ready, and it raises a valid flag. The product is twice the operand width. Only half of it is visible at a time, on a single operand-wide result port. A select input chooses which half is shown and can be changed freely while the product is held.

A build-time parameter sets how many multiplier bits are retired per cycle. With one bit per cycle, the multiplicand is gated by the current multiplier bit, which gives a 16-cycle operation at the default width. With four bits per cycle, a combinational multiplicand-by-nibble partial product is added each step, which gives a 4-cycle operation. The accumulator keeps the finished product and the flag stays high until the next accepted start.

Top module: `shift_add_mult`

## Requirements
- R1: When valid is high, the concatenation {upper half, lower half} read from result equals the unsigned product op_a × op_b of the accepted operands, for every 16-bit operand pair including 0 and 0xFFFF.
- R2: Operands are sampled only at the rising edge where start is accepted; later changes on op_a and op_b do not alter the product.
- R3: With STEP = 1, valid rises at the 16th rising edge after the edge that accepted start, and is low at every edge before that.
- R4: With STEP = 4, valid rises at the 4th rising edge after the accepting edge, and the product is identical to the STEP = 1 result.
- R5: hilo = 1 places product bits [31:16] on result, and hilo = 0 places bits [15:0] there. The selection is combinational, with no clock edge needed.
- R6: While no new start is accepted, valid stays high and the product stays unchanged, whatever op_a, op_b and hilo do.
- R7: A start seen at a rising edge while valid is high is accepted, and valid is low after that edge.
- R8: A start that arrives while an operation is in progress is ignored: the completion time and the product of the running operation do not change.
- R9: A synchronous reset (rst high at a rising edge) returns the block to idle with valid low and the product cleared, so result reads 0 for both values of hilo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, sampled at the rising edge |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier |
| hilo | input | 1 | 1 selects the upper product half, 0 the lower half |
| result | output | 16 | Selected half of the product |
| valid | output | 1 | Product complete and held |

## Verification
A start can land in the same cycle as the held result it is about to replace, and in the same cycle as a running operation that must not be disturbed. Both collisions are provoked on purpose. The bench pulses start in the middle of a run, with fresh random operands. It then checks that the completion edge and the product still match the first operand pair. It also restarts directly from the valid state and expects valid to fall at that same edge. Two instances, one bit per step and four bits per step, get identical stimulus. Each instance is judged against its own completion count, and both are judged against a product computed independently in the bench.

// File: rtl/mult_pkg.sv
package mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mult_state_e;

endpackage

// File: rtl/mult_pp.sv
// Partial product of the multiplicand and STEP multiplier bits.
module mult_pp #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input  logic [W-1:0]      m_i,
  input  logic [STEP-1:0]   d_i,
  output logic [W+STEP-1:0] pp_o
);

  localparam int PW = W + STEP;

  generate
    if (STEP == 1) begin : g_gate
      // Single bit: the multiplicand is either passed or blocked.
      assign pp_o = d_i[0] ? {1'b0, m_i} : '0;
    end else begin : g_array
      logic [PW-1:0] row [STEP];
      for (genvar i = 0; i < STEP; i++) begin : g_row
        assign row[i] = d_i[i] ? (PW'(m_i) << i) : '0;
      end
      always_comb begin
        pp_o = '0;
        for (int j = 0; j < STEP; j++) pp_o = pp_o + row[j];
      end
    end
  endgenerate

endmodule

// File: rtl/mult_fsm.sv
// Sequencing: idle, fixed-length run, hold.
module mult_fsm #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import mult_pkg::*;

  localparam int NSTEP = W / STEP;
  localparam int CW    = $clog2(NSTEP + 1);

  mult_state_e    state_q;
  logic [CW-1:0]  cnt_q;
  logic           last_w;

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = (state_q == ST_DONE);
  assign accept_o = start_i && !busy_o;
  assign step_o   = busy_o;
  assign last_w   = busy_o && (cnt_q == CW'(NSTEP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (accept_o) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (step_o) begin
      if (last_w) begin
        state_q <= ST_DONE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mult_datapath.sv
// Multiplicand register plus a double-width accumulator that starts with the
// multiplier in its lower half and shifts right by STEP each step.
module mult_datapath #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [2*W-1:0] prod_o
);

  localparam int PW = W + STEP;

  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] acc_q;
  logic [PW-1:0]  pp_w;

  // Upper half plus partial product, then drop the consumed multiplier bits.
  function automatic logic [2*W-1:0] add_shift(input logic [2*W-1:0] acc,
                                               input logic [PW-1:0]  pp);
    logic [PW-1:0] sum;
    sum = PW'(acc[2*W-1:W]) + pp;
    return {sum, acc[W-1:STEP]};
  endfunction

  mult_pp #(.W(W), .STEP(STEP)) u_pp (
    .m_i  (mcand_q),
    .d_i  (acc_q[STEP-1:0]),
    .pp_o (pp_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      acc_q   <= '0;
    end else if (load_i) begin
      mcand_q <= a_i;
      acc_q   <= {{W{1'b0}}, b_i};
    end else if (step_i) begin
      acc_q <= add_shift(acc_q, pp_w);
    end
  end

  assign prod_o = acc_q;

endmodule

// File: rtl/mult_outsel.sv
// Picks which product half appears on the narrow result port.
module mult_outsel #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] prod_i,
  input  logic           hilo_i,
  output logic [W-1:0]   res_o
);

  assign res_o = hilo_i ? prod_i[2*W-1:W] : prod_i[W-1:0];

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         hilo,
  output logic [W-1:0] result,
  output logic         valid
);

  logic           accept_w;
  logic           step_w;
  logic           busy_w;
  logic [2*W-1:0] prod_w;

  mult_fsm #(.W(W), .STEP(STEP)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .accept_o (accept_w),
    .step_o   (step_w),
    .busy_o   (busy_w),
    .done_o   (valid)
  );

  mult_datapath #(.W(W), .STEP(STEP)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept_w),
    .step_i (step_w),
    .a_i    (op_a),
    .b_i    (op_b),
    .prod_o (prod_w)
  );

  mult_outsel #(.W(W)) u_sel (
    .prod_i (prod_w),
    .hilo_i (hilo),
    .res_o  (result)
  );

endmodule

// File: rtl/mult_chk.sv
module mult_chk #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           hilo,
  input logic [W-1:0]   result,
  input logic           valid,
  input logic           busy,
  input logic           accept,
  input logic [2*W-1:0] prod
);

  localparam int NSTEP = W / STEP;
  localparam int YW    = $clog2(NSTEP + 1) + 1;

  logic [W-1:0]   a_cap, b_cap;
  logic [YW-1:0]  cyc;
  logic [2*W-1:0] want;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap <= '0;
      b_cap <= '0;
      cyc   <= '0;
    end else if (accept) begin
      a_cap <= op_a;
      b_cap <= op_b;
      cyc   <= '0;
    end else if (busy) begin
      cyc <= cyc + 1'b1;
    end
  end

  assign want = (2*W)'(a_cap) * (2*W)'(b_cap);

  // R1, R2, R4: completed product matches the operands held since acceptance
  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> prod == want);

  // R3, R4, R8: completion exactly NSTEP edges after acceptance
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> cyc == YW'(NSTEP));

  // R5
  a_r5_half_select: assert property (@(posedge clk) disable iff (rst)
    valid |-> result == (hilo ? prod[2*W-1:W] : prod[W-1:0]));

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !start) |=> (valid && $stable(prod)));

  // R7
  a_r7_restart_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (valid && start) |=> !valid);

  // R8: a start while running keeps the run going
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start && cyc < YW'(NSTEP - 1)) |=> busy);

  // R9
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid && !busy && prod == '0));

endmodule

bind shift_add_mult mult_chk #(.W(W), .STEP(STEP)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op_a   (op_a),
  .op_b   (op_b),
  .hilo   (hilo),
  .result (result),
  .valid  (valid),
  .busy   (busy_w),
  .accept (accept_w),
  .prod   (prod_w)
);

// File: tb/shift_add_mult_test.sv
module shift_add_mult_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        hilo = 1'b0;
  logic [15:0] res1, res4;
  logic        val1, val4;

  int n_chk = 0;
  int n_bad = 0;

  always #4ns clk = ~clk;

  shift_add_mult #(.W(16), .STEP(1)) uut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .hilo(hilo), .result(res1), .valid(val1)
  );

  shift_add_mult #(.W(16), .STEP(4)) uut4 (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .hilo(hilo), .result(res4), .valid(val4)
  );

  // Reference product: sum of the multiplier shifted by each set multiplicand bit.
  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] s = '0;
    for (int i = 15; i >= 0; i--) begin
      s = s << 1;
      if (a[i]) s = s + {16'h0, b};
    end
    return s;
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic read_prod(output logic [31:0] p1, output logic [31:0] p4);
    hilo = 1'b0;
    #1ns;
    p1[15:0] = res1;
    p4[15:0] = res4;
    hilo = 1'b1;
    #1ns;
    p1[31:16] = res1;
    p4[31:16] = res4;
  endtask

  // Called at a falling edge. Runs a whole operation.
  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit poke);
    logic [31:0] p1, p4, exp;
    exp   = ref_mul(a, b);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a  = 16'($urandom);   // R2: later operand changes must not matter
    op_b  = 16'($urandom);
    check("R7 valid low after accepting edge", {31'b0, val1}, 32'd0);
    check("R7 valid low after accepting edge (step4)", {31'b0, val4}, 32'd0);
    for (int k = 1; k <= 16; k++) begin
      if (poke && k == 3) begin
        start = 1'b1;        // R8: start mid-run
        op_a  = 16'($urandom);
        op_b  = 16'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      start = 1'b0;
      check("R3 valid timing", {31'b0, val1}, {31'b0, (k >= 16)});
      check("R4 valid timing (step4)", {31'b0, val4}, {31'b0, (k >= 4)});
    end
    read_prod(p1, p4);
    check(poke ? "R8 product after ignored start" : "R1 product", p1, exp);
    check(poke ? "R8 product after ignored start (step4)" : "R4 product", p4, exp);
    check("R5 upper half select", {16'h0, res1}, {16'h0, exp[31:16]});
    hilo = 1'b0;
    #1ns;
    check("R5 lower half select", {16'h0, res1}, {16'h0, exp[15:0]});
    @(negedge clk);
  endtask

  task automatic hold_test(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p1, p4, exp;
    exp = ref_mul(a, b);
    run_op(a, b, 1'b0);
    for (int k = 0; k < 4; k++) begin
      op_a = 16'($urandom);
      op_b = 16'($urandom);
      hilo = 1'($urandom);
      @(negedge clk);
      read_prod(p1, p4);
      check("R6 held product", p1, exp);
      check("R6 held product (step4)", p4, exp);
      check("R6 valid held", {30'b0, val1, val4}, 32'd3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] p1, p4;
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    read_prod(p1, p4);
    check("R9 reset product", p1, 32'd0);
    check("R9 reset product (step4)", p4, 32'd0);
    check("R9 reset valid", {30'b0, val1, val4}, 32'd0);

    // Directed corners
    run_op(16'h0000, 16'hBEEF, 1'b0);
    run_op(16'hFFFF, 16'hFFFF, 1'b0);
    run_op(16'hFFFF, 16'h0001, 1'b0);
    run_op(16'h0001, 16'hFFFF, 1'b0);
    run_op(16'h8000, 16'h0002, 1'b0);
    run_op(16'h1234, 16'h0000, 1'b0);
    run_op(16'hA5A5, 16'h5A5A, 1'b1);
    hold_test(16'hC3C3, 16'h0F0F);
    // R7: restart directly from the held state (run_op checks valid drop)
    run_op(16'h00FF, 16'hFF00, 1'b0);

    // Random operands, some with a mid-run start
    for (int i = 0; i < 40; i++) begin
      run_op(16'($urandom), 16'($urandom), (i % 5) == 2);
    end

    // R9: reset in the middle of a run
    op_a  = 16'hFFFF;
    op_b  = 16'hFFFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    read_prod(p1, p4);
    check("R9 mid-run reset product", p1, 32'd0);
    check("R9 mid-run reset product (step4)", p4, 32'd0);
    repeat (20) @(negedge clk);
    check("R9 stays idle after reset", {30'b0, val1, val4}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule